// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flags

This block holds a bank of status flags. Each flag is set by its own hardware event and cleared by a two-step software handshake. The first step is a read of the status register. It arms every flag that reads as 1 at that moment. The second step is any read or write of a companion register. That access clears every armed flag. Flags that were not armed by an earlier status read are never cleared, so an event that arrives between the two steps cannot be lost.

A debugger may halt the system and then inspect registers freely. While the debug-halt level is high and the halt-clear permission bit is low, no access can clear or arm anything. A debugger read therefore never destroys status. When the permission bit is high, the handshake works during the halt just as it does outside it. The armed state is a plain register that ignores halt entry and halt exit. A status read done before the halt still completes with a companion access made after the halt ends. A flag cleared during a halt stays cleared once the halt is over.

Top module: `brkflag_reg`

## Requirements
- R1: A synchronous active-low reset (rst_n low at a rising clock edge) sets every flag bit and every armed bit to 0 at that edge.
- R2: A 1 on set_evt[i] at a rising edge makes flag[i] equal to 1 after that edge.
- R3: A 1 on stat_rd while flag[i] is 1 and clearing is permitted makes armed[i] equal to 1 after the edge. Clearing is permitted when brk_on is 0 or brk_clr_en is 1. A status read while flag[i] is 0 leaves armed[i] at 0. armed[i] is never 1 while flag[i] is 0.
- R4: A 1 on aux_acc while armed[i] is 1, clearing is permitted and set_evt[i] is 0 clears both flag[i] and armed[i] at that edge.
- R5: A companion access with armed[i] at 0 has no effect on flag[i]. The only way a flag falls, other than reset, is the R4 step.
- R6: While brk_on is 1 and brk_clr_en is 0, stat_rd and aux_acc change neither the flags nor the armed bits.
- R7: While brk_on is 1 and brk_clr_en is 1, the two-step clear of R3 and R4 works as it does outside a halt.
- R8: An armed bit set before a halt stays 1 through the halt and through halt exit. A companion access after exit then clears the flag.
- R9: A flag cleared during a halt remains 0 after brk_on returns to 0.
- R10: If set_evt[i] and a clearing companion access occur at the same edge, flag[i] stays 1 and armed[i] becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| set_evt | input | N_FLAGS | Per-flag hardware set event, one cycle per pulse |
| stat_rd | input | 1 | Status register read strobe (clear step one) |
| aux_acc | input | 1 | Companion register read-or-write strobe (clear step two) |
| brk_on | input | 1 | Debug halt active level |
| brk_clr_en | input | 1 | Permit clearing during a halt |
| flag | output | N_FLAGS | Status flag bits |
| armed | output | N_FLAGS | Per-flag armed indication |

## Verification
A wrong armed bit shows at the ports within one edge, either as armed[i] disagreeing with the expected value or at the next companion access as a flag that falls too early or does not fall. Because armed survives halts indefinitely, a gating fault in the halt path may stay hidden until the first companion access after the halt ends. The bench therefore always follows a halt with a post-exit access. A bench model steps alongside the block and compares both output vectors after every edge, so a divergence is reported at the cycle it appears rather than at a later directed check.

// File: rtl/brkflag_pkg.sv
package brkflag_pkg;

   localparam int unsigned MAX_FLAGS = 32;

   // Per-cycle qualified access controls shared by all flag cells.
   typedef struct packed {
      logic arm_req;    // status read, gated by the permission
      logic clr_req;    // companion access, gated by the permission
   } acc_ctl_t;

endpackage

// File: rtl/brkflag_gate.sv
module brkflag_gate
   import brkflag_pkg::*;
(
   input  logic     stat_rd,
   input  logic     aux_acc,
   input  logic     brk_on,
   input  logic     brk_clr_en,
   output acc_ctl_t ctl
);

   logic permit;

   always_comb begin
      permit      = (~brk_on) | brk_clr_en;
      ctl.arm_req = stat_rd & permit;
      ctl.clr_req = aux_acc & permit;
   end

endmodule

// File: rtl/brkflag_cell.sv
module brkflag_cell
   import brkflag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     set_evt,
   input  acc_ctl_t ctl,
   output logic     flag_q,
   output logic     armed_q
);

   logic clr_hit;
   logic arm_hit;
   logic flag_d;
   logic armed_d;

   always_comb begin
      clr_hit = ctl.clr_req & armed_q;
      arm_hit = ctl.arm_req & flag_q;
      // a fresh event beats a completing clear
      if (set_evt)      flag_d = 1'b1;
      else if (clr_hit) flag_d = 1'b0;
      else              flag_d = flag_q;
      if (clr_hit)      armed_d = 1'b0;
      else if (arm_hit) armed_d = 1'b1;
      else              armed_d = armed_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         flag_q  <= flag_d;
         armed_q <= armed_d;
      end
   end

endmodule

// File: rtl/brkflag_reg.sv
module brkflag_reg
   import brkflag_pkg::*;
#(
   parameter int unsigned N_FLAGS = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] set_evt,
   input  logic               stat_rd,
   input  logic               aux_acc,
   input  logic               brk_on,
   input  logic               brk_clr_en,
   output logic [N_FLAGS-1:0] flag,
   output logic [N_FLAGS-1:0] armed
);

   localparam int unsigned LAST = N_FLAGS - 1;

   if (N_FLAGS < 1 || N_FLAGS > MAX_FLAGS) begin : g_bad_width
      $error("brkflag_reg: N_FLAGS out of range");
   end

   acc_ctl_t ctl;

   brkflag_gate u_gate (
      .stat_rd    (stat_rd),
      .aux_acc    (aux_acc),
      .brk_on     (brk_on),
      .brk_clr_en (brk_clr_en),
      .ctl        (ctl)
   );

   for (genvar i = 0; i <= LAST; i++) begin : g_cell
      brkflag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (set_evt[i]),
         .ctl     (ctl),
         .flag_q  (flag[i]),
         .armed_q (armed[i])
      );
   end

endmodule

// File: rtl/brkflag_chk.sv
module brkflag_chk #(
   parameter int unsigned N_FLAGS = 8
)(
   input logic               clk,
   input logic               rst_n,
   input logic [N_FLAGS-1:0] set_evt,
   input logic               stat_rd,
   input logic               aux_acc,
   input logic               brk_on,
   input logic               brk_clr_en,
   input logic [N_FLAGS-1:0] flag,
   input logic [N_FLAGS-1:0] armed
);

   logic ok;
   assign ok = !brk_on || brk_clr_en;

   a_r1_reset: assert property (@(posedge clk)
      !rst_n |=> (flag == '0 && armed == '0));

   for (genvar i = 0; i < N_FLAGS; i++) begin : g_bit
      a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
         set_evt[i] |=> flag[i]);
      a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_rd && flag[i] && ok && !(aux_acc && armed[i])) |=> armed[i]);
      a_r3_armed_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
         armed[i] |-> flag[i]);
      a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (aux_acc && armed[i] && ok && !set_evt[i]) |=> (!flag[i] && !armed[i]));
      a_r5_only_step_two: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[i] && !(aux_acc && armed[i] && ok)) |=> flag[i]);
      a_r6_no_arm_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
         (brk_on && !brk_clr_en && !armed[i]) |=> !armed[i]);
      a_r8_armed_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (brk_on && !brk_clr_en && armed[i]) |=> armed[i]);
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (set_evt[i] && aux_acc && armed[i] && ok) |=> (flag[i] && !armed[i]));
   end

endmodule

bind brkflag_reg brkflag_chk #(.N_FLAGS(N_FLAGS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .set_evt    (set_evt),
   .stat_rd    (stat_rd),
   .aux_acc    (aux_acc),
   .brk_on     (brk_on),
   .brk_clr_en (brk_clr_en),
   .flag       (flag),
   .armed      (armed)
);

// File: tb/tb_brkflag_reg.sv
`timescale 1ns/1ps
module tb_brkflag_reg;

   localparam int NF = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] set_evt = '0;
   logic          stat_rd = 1'b0;
   logic          aux_acc = 1'b0;
   logic          brk_on = 1'b0;
   logic          brk_clr_en = 1'b0;
   logic [NF-1:0] flag;
   logic [NF-1:0] armed;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural reference state
   bit m_flag [NF];
   bit m_arm  [NF];

   always #2.5 clk = ~clk;

   brkflag_reg #(.N_FLAGS(NF)) dut (
      .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .stat_rd(stat_rd),
      .aux_acc(aux_acc), .brk_on(brk_on), .brk_clr_en(brk_clr_en),
      .flag(flag), .armed(armed)
   );

   function automatic logic [NF-1:0] pack(input bit v [NF]);
      logic [NF-1:0] r;
      for (int k = 0; k < NF; k++) r[k] = v[k];
      return r;
   endfunction

   // model update, one call per rising edge with the inputs of that edge
   task automatic model_step();
      bit may_clear;
      may_clear = (brk_on == 1'b0) || (brk_clr_en == 1'b1);
      for (int k = 0; k < NF; k++) begin
         bit wipe, hold;
         if (rst_n == 1'b0) begin
            m_flag[k] = 0; m_arm[k] = 0;
         end else begin
            wipe = aux_acc && m_arm[k] && may_clear;
            hold = stat_rd && m_flag[k] && may_clear;
            if (wipe) m_arm[k] = 0; else if (hold) m_arm[k] = 1;
            if (set_evt[k]) m_flag[k] = 1; else if (wipe) m_flag[k] = 0;
         end
      end
   endtask

   task automatic compare();
      checks++;
      if (flag !== pack(m_flag) || armed !== pack(m_arm)) begin
         errors++;
         $display("FAIL %s: flag=%b armed=%b expected flag=%b armed=%b",
                  tag, flag, armed, pack(m_flag), pack(m_arm));
      end
   endtask

   task automatic expect_vals(input string req, input logic [NF-1:0] ef, input logic [NF-1:0] ea);
      checks++;
      if (flag !== ef || armed !== ea) begin
         errors++;
         $display("FAIL %s: flag=%b armed=%b expected flag=%b armed=%b",
                  req, flag, armed, ef, ea);
      end
   endtask

   // drive one cycle of inputs, let the edge pass, compare at negedge
   task automatic cyc(input logic [NF-1:0] s, input logic rd, input logic ac,
                      input logic b, input logic be);
      set_evt = s; stat_rd = rd; aux_acc = ac; brk_on = b; brk_clr_en = be;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      // R1: reset
      tag = "R1";
      rst_n = 1'b0;
      repeat (3) cyc(4'b0000, 0, 0, 0, 0);
      expect_vals("R1", 4'b0000, 4'b0000);
      rst_n = 1'b1;

      tag = "R2";
      cyc(4'b0101, 0, 0, 0, 0);
      expect_vals("R2", 4'b0101, 4'b0000);

      tag = "R5";
      cyc(4'b0000, 0, 1, 0, 0);
      expect_vals("R5", 4'b0101, 4'b0000);

      tag = "R3";
      cyc(4'b0000, 1, 0, 0, 0);
      expect_vals("R3", 4'b0101, 4'b0101);
      cyc(4'b0010, 0, 0, 0, 0);   // flag1 set after the read: not armed
      expect_vals("R3", 4'b0111, 4'b0101);

      tag = "R4";
      cyc(4'b0000, 0, 1, 0, 0);
      expect_vals("R4", 4'b0010, 4'b0000);
      cyc(4'b0000, 1, 0, 0, 0);
      cyc(4'b0000, 0, 1, 0, 0);
      expect_vals("R4", 4'b0000, 4'b0000);

      tag = "R6";
      cyc(4'b1001, 0, 0, 0, 0);
      cyc(4'b0000, 1, 0, 1, 0);
      cyc(4'b0000, 0, 1, 1, 0);
      cyc(4'b0000, 1, 1, 1, 0);
      expect_vals("R6", 4'b1001, 4'b0000);

      tag = "R7";
      cyc(4'b0000, 1, 0, 1, 1);
      expect_vals("R7", 4'b1001, 4'b1001);
      cyc(4'b0000, 0, 1, 1, 1);
      expect_vals("R7", 4'b0000, 4'b0000);

      tag = "R9";
      cyc(4'b0000, 0, 0, 0, 0);
      expect_vals("R9", 4'b0000, 4'b0000);

      tag = "R8";
      cyc(4'b0110, 0, 0, 0, 0);
      cyc(4'b0000, 1, 0, 0, 0);
      cyc(4'b0000, 0, 1, 1, 0);
      cyc(4'b0000, 1, 1, 1, 0);
      expect_vals("R8", 4'b0110, 4'b0110);
      cyc(4'b0000, 0, 0, 0, 0);
      expect_vals("R8", 4'b0110, 4'b0110);
      cyc(4'b0000, 0, 1, 0, 0);
      expect_vals("R8", 4'b0000, 4'b0000);

      tag = "R10";
      cyc(4'b0011, 0, 0, 0, 0);
      cyc(4'b0000, 1, 0, 0, 0);
      cyc(4'b0001, 0, 1, 0, 0);
      expect_vals("R10", 4'b0001, 4'b0000);

      tag = "R1";
      cyc(4'b1111, 1, 0, 0, 0);
      rst_n = 1'b0;
      cyc(4'b1111, 0, 0, 0, 0);
      expect_vals("R1", 4'b0000, 4'b0000);
      rst_n = 1'b1;

      tag = "RND";
      for (int n = 0; n < 3000; n++) begin
         logic [NF-1:0] s;
         s = NF'($urandom_range(0, 15) & $urandom_range(0, 15));
         rst_n = ($urandom_range(0, 199) != 0);
         cyc(s, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
             $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 0);
      end
      rst_n = 1'b1;
      finish_run();
   end

endmodule